// File: doc/BRIEF.md
# Rotating FIFO-fed output shifter

The block is the word-wide serialiser at the head of a high-speed output path. It pulls 32-bit words from a transmit FIFO over a valid/ready read port and holds each word in a register. On every following enabled cycle it right-rotates that register by a programmable amount. Downstream pin logic taps whatever bits it needs from the register contents. A strobe marks each cycle in which the register moved.

Each word is rotated a programmed number of times and the block then asks the FIFO for the next word. That number is a count of rotations, not a bit distance, and a programmed count of zero means a full 32 rotations. Because the operation is a rotation, bits are never lost. A rotate amount of 32 minus k behaves as a left shift by k, and an amount times count larger than 32 repeats the word's bits. Dropping the enable discards any rotations still pending. The block then waits until it is enabled again, at which point it takes a fresh word.

Top module: `rfs_top`

## Requirements
- R1: After a synchronous active-low reset, `sreg_q` is all zeros, and `shift_stb` and `fifo_ready` are low while `en` is low.
- R2: `fifo_ready` is high exactly when `en` is high and no rotations of the current word are pending. On a cycle with `fifo_ready` and `fifo_valid` both high, `sreg_q` takes `fifo_data` unrotated at the next edge, and `shift_stb` is low in that cycle.
- R3: In every cycle with `shift_stb` high, the next `sreg_q` equals the current `sreg_q` rotated right by `rot_amt`, where bit i moves to bit (i - rot_amt) mod 32. `rot_amt` is sampled live on every rotation. An amount of 0 leaves the contents unchanged, and an amount of 31 acts as a left rotation by one.
- R4: A word loaded while `rot_cnt` = n (1 to 31) gets exactly n rotations, one per enabled cycle, and `fifo_ready` rises in the cycle after the last of them. `rot_cnt` is sampled only at the load.
- R5: A load with `rot_cnt` = 0 gives 32 rotations before the next request.
- R6: When `rot_amt` times the count exceeds 32, the rotation wraps past the word and the word's bits appear again. For example, amount 16 with count 4 returns the loaded word after 2 and after 4 rotations.
- R7: While `fifo_ready` is high and `fifo_valid` is low, `sreg_q` holds and `shift_stb` stays low. The word is loaded in the first cycle `fifo_valid` is high.
- R8: While `en` is low, `fifo_ready` and `shift_stb` are low, `sreg_q` holds, and any pending rotations are discarded. In the first enabled cycle after that, `fifo_ready` is high.
- R9: `shift_stb` is high exactly in the cycles in which the register rotates, and it is never high together with `fifo_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low discards pending rotations |
| rot_amt | input | 5 | Right-rotate distance per rotation |
| rot_cnt | input | 5 | Rotations per word, 0 means 32 |
| fifo_valid | input | 1 | FIFO has a word |
| fifo_data | input | 32 | FIFO head word |
| fifo_ready | output | 1 | Pop request; a word is taken when valid is also high |
| sreg_q | output | 32 | Current register contents |
| shift_stb | output | 1 | Register rotates at the coming edge |

## Verification
A wrong pending-rotation count has a visible symptom: `fifo_ready` and `shift_stb` trade places one cycle early or late. This shows at the first word boundary, at most 33 cycles after a load. A faulty rotator stage or a wrong load mux gives a wrong `sreg_q` at the very next edge. A disable that does not clear the count leaves `fifo_ready` low in the first re-enabled cycle. A starvation path that still moves the register changes `sreg_q` while `fifo_ready` is high.

// File: rtl/rfs_pkg.sv
// Package: shared widths and types for the rotating output shifter.
// Assumes the word width is a power of two so that a rotate amount of
// log2(width) bits covers every distance.
package rfs_pkg;
    localparam int WORD_W = 32;
    localparam int AMT_W  = $clog2(WORD_W);
    localparam int CNT_W  = AMT_W + 1;

    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/rfs_counter.sv
// Module: pending-rotation counter.
// Holds how many rotations of the current word remain. It is loaded on a
// FIFO pop and cleared whenever the block is disabled. Zero means a word is
// needed. Assumes load is only raised while the counter is empty.
module rfs_counter #(
    parameter int W     = rfs_pkg::WORD_W,
    parameter int AW    = $clog2(W),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [AW-1:0] n_in,
    output logic          empty,
    output logic          advance
);
    logic [CW-1:0] left;
    logic [CW-1:0] n_full;

    // Map a programmed count of zero to a full word of rotations.
    assign n_full  = (n_in == '0) ? CW'(W) : CW'(n_in);
    assign empty   = (left == '0);
    assign advance = en && !empty;

    // Track the rotations still owed to the current word.
    always_ff @(posedge clk) begin
        if (!rst_n)       left <= '0;
        else if (!en)     left <= '0;
        else if (load)    left <= n_full;
        else if (advance) left <= left - CW'(1);
    end

    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> empty);
    // R4
    load_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !empty);
endmodule

// File: rtl/rfs_datareg.sv
// Module: data register with a logarithmic right rotator.
// Loads a new word or replaces its contents with a right rotation by a
// live amount. Assumes W is a power of two and that load and advance are
// never high together.
module rfs_datareg #(
    parameter int W  = rfs_pkg::WORD_W,
    parameter int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          advance,
    input  logic [AW-1:0] amt,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  q
);
    logic [W-1:0] stage [AW+1];

    assign stage[0] = q;

    // One rotator stage per amount bit; stage s rotates by 2**s when enabled.
    for (genvar s = 0; s < AW; s++) begin : g_rot
        localparam int K = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][K-1:0], stage[s][W-1:K]}
                                   : stage[s];
    end

    // Register update: load wins, otherwise rotate on advance, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load)    q <= din;
        else if (advance) q <= stage[AW];
    end

    // R3
    rotate_keeps_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> ($countones(q) == $countones($past(q))));
endmodule

// File: rtl/rfs_top.sv
// Module: rotating FIFO-fed output shifter (top).
// Requests a word when no rotations are pending, loads it without rotating,
// then rotates it once per enabled cycle for the programmed count. Assumes
// the FIFO presents its head word with valid and pops on valid and ready.
module rfs_top #(
    parameter int W  = rfs_pkg::WORD_W,
    parameter int AW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [AW-1:0] rot_amt,
    input  logic [AW-1:0] rot_cnt,
    input  logic          fifo_valid,
    input  logic [W-1:0]  fifo_data,
    output logic          fifo_ready,
    output logic [W-1:0]  sreg_q,
    output logic          shift_stb
);
    logic empty;
    logic advance;
    logic load;

    // Handshake: ask for data only while enabled and idle.
    assign fifo_ready = en && empty;
    assign load       = fifo_ready && fifo_valid;
    assign shift_stb  = advance;

    rfs_counter #(.W(W), .AW(AW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .load    (load),
        .n_in    (rot_cnt),
        .empty   (empty),
        .advance (advance)
    );

    rfs_datareg #(.W(W), .AW(AW)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .amt     (rot_amt),
        .din     (fifo_data),
        .q       (sreg_q)
    );

    // R2
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ready && fifo_valid) |=> (sreg_q == $past(fifo_data)));
    // R7
    starve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ready && !fifo_valid) |=> $stable(sreg_q));
    // R9
    stb_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_stb, fifo_ready}));
    // R8
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(sreg_q));
endmodule

// File: tb/rfs_top_test.sv
// Bench: directed scenarios against a cycle model built from the requirements.
module rfs_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [4:0]  rot_amt = '0;
    logic [4:0]  rot_cnt = '0;
    logic        fifo_valid = 1'b0;
    logic [31:0] fifo_data = '0;
    logic        fifo_ready;
    logic [31:0] sreg_q;
    logic        shift_stb;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] m_sreg = '0;
    int          m_left = 0;

    always #5 clk = ~clk;

    rfs_top uut (
        .clk(clk), .rst_n(rst_n), .en(en), .rot_amt(rot_amt), .rot_cnt(rot_cnt),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_ready(fifo_ready),
        .sreg_q(sreg_q), .shift_stb(shift_stb)
    );

    function automatic logic [31:0] rotr(input logic [31:0] x, input int k);
        return (k == 0) ? x : ((x >> k) | (x << (32 - k)));
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare, advance the model.
    task automatic step(input logic e, input logic v, input logic [31:0] d,
                        input logic [4:0] a, input logic [4:0] n, input string tag);
        logic xr, xs;
        en = e; fifo_valid = v; fifo_data = d; rot_amt = a; rot_cnt = n;
        #1;
        xr = e && (m_left == 0);
        xs = e && (m_left != 0);
        chk(tag, "sreg_q", sreg_q, m_sreg);
        chk(tag, "fifo_ready", {31'b0, fifo_ready}, {31'b0, xr});
        chk(tag, "shift_stb", {31'b0, shift_stb}, {31'b0, xs});
        if (!e) m_left = 0;
        else if (m_left != 0) begin m_sreg = rotr(m_sreg, a); m_left--; end
        else if (v) begin m_sreg = d; m_left = (n == 0) ? 32 : n; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1
        step(0, 1, 32'hDEAD_BEEF, 0, 0, "R1");
        chk("R1", "sreg_q after reset", sreg_q, 32'h0);
    endtask

    task automatic t_basic();
        // R2 R4 R9: count 3, amount 4, two back-to-back words
        step(1, 1, 32'h1234_5678, 4, 3, "R2");
        chk("R2", "loaded word", sreg_q, 32'h1234_5678);
        step(1, 1, 32'hAAAA_0000, 4, 3, "R3");
        chk("R3", "rotate by 4", sreg_q, 32'h8123_4567);
        step(1, 1, 32'hAAAA_0000, 4, 3, "R4");
        step(1, 1, 32'hAAAA_0000, 4, 3, "R4");
        step(1, 1, 32'hAAAA_0000, 4, 7, "R4");
        step(1, 0, 32'h0, 8, 7, "R9");
        step(1, 0, 32'h0, 8, 7, "R9");
        step(1, 0, 32'h0, 8, 7, "R9");
    endtask

    task automatic t_full_count();
        // R5: count 0 means 32 rotations by 1, returning the word
        while (m_left != 0) step(1, 0, 32'h0, 1, 0, "R5");
        step(1, 1, 32'hC001_0003, 1, 0, "R5");
        for (int i = 0; i < 32; i++) step(1, 0, 32'h0, 1, 0, "R5");
        chk("R5", "word after 32 rotations", sreg_q, 32'hC001_0003);
        chk("R5", "ready after 32", {31'b0, fifo_ready}, 32'h1);
    endtask

    task automatic t_repeat_and_left();
        // R6: amount 16 count 4 repeats the word
        step(1, 1, 32'h0000_FFFF, 16, 4, "R6");
        step(1, 0, 32'h0, 16, 4, "R6");
        chk("R6", "half swap", sreg_q, 32'hFFFF_0000);
        step(1, 0, 32'h0, 16, 4, "R6");
        chk("R6", "word repeats", sreg_q, 32'h0000_FFFF);
        step(1, 0, 32'h0, 16, 4, "R6");
        step(1, 0, 32'h0, 16, 4, "R6");
        // R3: amount 31 = left by one, then amount 0 holds, live amount change
        step(1, 1, 32'h0000_0001, 31, 3, "R3");
        step(1, 0, 32'h0, 31, 3, "R3");
        chk("R3", "left emulation", sreg_q, 32'h0000_0002);
        step(1, 0, 32'h0, 0, 3, "R3");
        chk("R3", "amount 0 holds", sreg_q, 32'h0000_0002);
        step(1, 0, 32'h0, 2, 3, "R3");
        chk("R3", "live amount 2", sreg_q, 32'h8000_0000);
    endtask

    task automatic t_starve();
        // R7: FIFO empty at expiry, then data arrives
        for (int i = 0; i < 4; i++) step(1, 0, 32'h5555_5555, 3, 2, "R7");
        chk("R7", "hold while starved", sreg_q, 32'h8000_0000);
        step(1, 1, 32'h0F0F_0F0F, 3, 2, "R7");
        chk("R7", "resume load", sreg_q, 32'h0F0F_0F0F);
        step(1, 0, 32'h0, 3, 2, "R7");
    endtask

    task automatic t_disable();
        // R8: drop enable mid-word with data offered
        for (int i = 0; i < 3; i++) step(0, 1, 32'h7777_7777, 5, 9, "R8");
        chk("R8", "held while off", sreg_q, rotr(32'h0F0F_0F0F, 3));
        step(1, 1, 32'h1357_9BDF, 5, 2, "R8");
        chk("R8", "fresh word after enable", sreg_q, 32'h1357_9BDF);
        step(1, 0, 32'h0, 5, 2, "R8");
        step(1, 0, 32'h0, 5, 2, "R8");
        step(0, 0, 32'h0, 5, 2, "R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_full_count();
        t_repeat_and_left();
        t_starve();
        t_disable();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule